// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Sample Buffer

This block sits between a sample producer in the receiver clock domain and a consumer processor in its own clock domain. The storage is one dual-port RAM split into two banks. At any time the producer writes one bank and the consumer reads the other. When the producer has finished capturing a symbol, it pulses a done strobe. If the consumer is not busy and no earlier swap is still in flight, the banks trade roles.

The swap crosses the clock boundary with a toggle request and a toggle acknowledge, each passed through a two-flop synchronizer. On the read side, a completed swap flips the read bank, raises a ready flag and fires a one-cycle interrupt. The consumer holds a busy input high while it works on its bank, and that input clears the ready flag. The busy level is registered on the read side and synchronized into the write side, where it blocks swaps. A done strobe that cannot be honoured throws the new symbol away. The write bank stays where it is, and a sticky overrun flag is set. Bank depth and word width are parameters.

Top module: `pingpong_buf`

## Requirements
- R1: After reset, wr_bank_o is 0, rd_bank_o is 1, and data_rdy_o, irq_o and overrun_o are all 0.
- R2: A word written with wr_en_i at wr_addr_i goes into the bank shown on wr_bank_o. Once that bank becomes the read bank, the word is returned on rd_data_o one rd_clk_i edge after rd_addr_i is sampled.
- R3: A wr_done_i accepted while the consumer is idle and no swap is pending flips wr_bank_o at that wr_clk_i edge. wr_bank_o never changes without wr_done_i.
- R4: Each accepted swap flips rd_bank_o exactly once. In the same read cycle, data_rdy_o rises and irq_o is high for exactly one rd_clk_i cycle.
- R5: data_rdy_o is 0 one rd_clk_i edge after cons_busy_i is sampled high, unless a swap lands on that same edge.
- R6: A wr_done_i is dropped if it arrives while the synchronized cons_busy_i is high, or while an earlier swap is still unacknowledged. In that case wr_bank_o and the read bank contents stay unchanged and overrun_o becomes 1 on that edge.
- R7: overrun_o stays 1 until ovr_clr_i. If a drop and ovr_clr_i fall on the same edge, the flag stays set.
- R8: Once a swap handshake has settled, rd_bank_o is the complement of wr_bank_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Producer clock |
| rd_clk_i | input | 1 | Consumer clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | BANK_AW | Word address within the write bank |
| wr_data_i | input | DATA_W | Write data |
| wr_done_i | input | 1 | Producer finished the current symbol |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| wr_bank_o | output | 1 | Bank currently written |
| overrun_o | output | 1 | Sticky dropped-symbol flag |
| rd_addr_i | input | BANK_AW | Word address within the read bank |
| rd_data_o | output | DATA_W | Registered read data |
| rd_bank_o | output | 1 | Bank currently offered to the consumer |
| data_rdy_o | output | 1 | New bank ready for the consumer |
| irq_o | output | 1 | One-cycle pulse per completed swap |
| cons_busy_i | input | 1 | Consumer is working on the read bank |

## Verification
Two cases are hard to reach from the ports. The first is a done strobe that arrives while the previous request is still crossing to the read side. The stimulus produces it by holding wr_done_i high for two consecutive producer cycles, so the second cycle sees an unacknowledged toggle. The second case is a drop caused by the consumer being busy. This needs cons_busy_i held long enough to pass through both synchronizer stages. The bench then reads back the read bank to show that the dropped symbol never reached it. A third edge holds a drop and a clear together to show which one wins.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_BANK_AW = 10;

  typedef enum logic {
    BANK_PING = 1'b0,
    BANK_PONG = 1'b1
  } bank_e;
endpackage

// File: rtl/ppb_sync.sv
module ppb_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ppb_dpram.sv
module ppb_dpram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 11
) (
  input  logic              wr_clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ppb_wr_ctrl.sv
module ppb_wr_ctrl
  import ppb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  done_i,
  input  logic  clr_i,
  input  logic  busy_s_i,
  input  logic  ack_s_i,
  output logic  req_o,
  output bank_e bank_o,
  output logic  ovr_o
);
  logic  req_q, ovr_q;
  bank_e bank_q;
  logic  pending, accept, drop;

  assign pending = (req_q != ack_s_i);
  assign accept  = done_i && !busy_s_i && !pending;
  assign drop    = done_i && !accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      bank_q <= BANK_PING;
      ovr_q  <= 1'b0;
    end else begin
      if (accept) begin
        req_q  <= ~req_q;
        bank_q <= bank_e'(~bank_q);
      end
      // a new drop outranks a clear on the same edge
      if (drop)       ovr_q <= 1'b1;
      else if (clr_i) ovr_q <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign bank_o = bank_q;
  assign ovr_o  = ovr_q;

  AST_SWAP_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(bank_q)); // R3
  AST_DROP_HOLDS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && (busy_s_i || (req_q != ack_s_i)) |=> $stable(bank_q) && ovr_q); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !clr_i |=> ovr_q); // R7
endmodule

// File: rtl/ppb_rd_ctrl.sv
module ppb_rd_ctrl
  import ppb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_s_i,
  input  logic  busy_i,
  output logic  ack_o,
  output bank_e bank_o,
  output logic  rdy_o,
  output logic  irq_o,
  output logic  busy_q_o
);
  logic  seen_q, rdy_q, irq_q, busy_q;
  bank_e bank_q;
  logic  swap;

  assign swap = (req_s_i != seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      bank_q <= BANK_PONG;
      rdy_q  <= 1'b0;
      irq_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      irq_q  <= swap;
      if (swap) begin
        seen_q <= req_s_i;
        bank_q <= bank_e'(~bank_q);
        rdy_q  <= 1'b1;
      end else if (busy_i) begin
        rdy_q  <= 1'b0;
      end
    end
  end

  assign ack_o    = seen_q;
  assign bank_o   = bank_q;
  assign rdy_o    = rdy_q;
  assign irq_o    = irq_q;
  assign busy_q_o = busy_q;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q); // R4
  AST_RDY_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> irq_q); // R4
  AST_BANK_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_q) |-> irq_q); // R4
  AST_BUSY_DROPS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && (req_s_i == seen_q) |=> !rdy_q); // R5
endmodule

// File: rtl/pingpong_buf.sv
module pingpong_buf
  import ppb_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned BANK_AW = DEF_BANK_AW
) (
  input  logic               wr_clk_i,
  input  logic               rd_clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [BANK_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               wr_done_i,
  input  logic               ovr_clr_i,
  output logic               wr_bank_o,
  output logic               overrun_o,
  input  logic [BANK_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_bank_o,
  output logic               data_rdy_o,
  output logic               irq_o,
  input  logic               cons_busy_i
);
  localparam int unsigned MEM_AW = BANK_AW + 1;

  logic  req, ack, req_s, ack_s, busy_q, busy_s;
  bank_e wr_bank, rd_bank;

  ppb_wr_ctrl u_wr_ctrl (
    .clk_i    (wr_clk_i),
    .rst_ni   (rst_ni),
    .done_i   (wr_done_i),
    .clr_i    (ovr_clr_i),
    .busy_s_i (busy_s),
    .ack_s_i  (ack_s),
    .req_o    (req),
    .bank_o   (wr_bank),
    .ovr_o    (overrun_o)
  );

  ppb_sync #(.W(2)) u_sync_to_wr (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ack, busy_q}),
    .q_o    ({ack_s, busy_s})
  );

  ppb_sync #(.W(1)) u_sync_to_rd (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    (req),
    .q_o    (req_s)
  );

  ppb_rd_ctrl u_rd_ctrl (
    .clk_i    (rd_clk_i),
    .rst_ni   (rst_ni),
    .req_s_i  (req_s),
    .busy_i   (cons_busy_i),
    .ack_o    (ack),
    .bank_o   (rd_bank),
    .rdy_o    (data_rdy_o),
    .irq_o    (irq_o),
    .busy_q_o (busy_q)
  );

  ppb_dpram #(.DATA_W(DATA_W), .AW(MEM_AW)) u_mem (
    .wr_clk_i (wr_clk_i),
    .we_i     (wr_en_i),
    .waddr_i  ({wr_bank, wr_addr_i}),
    .wdata_i  (wr_data_i),
    .rd_clk_i (rd_clk_i),
    .rst_ni   (rst_ni),
    .raddr_i  ({rd_bank, rd_addr_i}),
    .rdata_o  (rd_data_o)
  );

  assign wr_bank_o = wr_bank;
  assign rd_bank_o = rd_bank;
endmodule

// File: tb/pingpong_buf_tb.sv
module pingpong_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DATA_W  = 32;
  localparam int BANK_AW = 10;
  localparam int DEPTH   = 1 << BANK_AW;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en = 0, wr_done = 0, ovr_clr = 0, cons_busy = 0;
  logic [BANK_AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic [DATA_W-1:0]  rd_data;
  logic wr_bank, overrun, rd_bank, data_rdy, irq;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  pingpong_buf #(.DATA_W(DATA_W), .BANK_AW(BANK_AW)) u_dut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_done_i(wr_done), .ovr_clr_i(ovr_clr),
    .wr_bank_o(wr_bank), .overrun_o(overrun),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_bank_o(rd_bank),
    .data_rdy_o(data_rdy), .irq_o(irq), .cons_busy_i(cons_busy)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, ended = 0;
  logic exp_bank = 0, exp_ovr = 0, exp_pend = 0;
  logic [DATA_W-1:0] sb [2][DEPTH];
  int addrs [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // per-cycle compare of the write-domain model
  always @(negedge wr_clk) if (cmp_on) begin
    check(wr_bank == exp_bank, "R3 wr_bank", wr_bank, exp_bank);
    check(overrun == exp_ovr, "R6/R7 overrun", overrun, exp_ovr);
  end

  task automatic wr_word(input int a, input logic [DATA_W-1:0] d);
    @(negedge wr_clk);
    wr_en = 1; wr_addr = a[BANK_AW-1:0]; wr_data = d;
    sb[exp_bank][a] = d;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  // done held for n cycles; clr optionally asserted alongside
  task automatic done_cycles(input int n, input bit clr);
    @(negedge wr_clk);
    wr_done = 1; ovr_clr = clr;
    for (int i = 0; i < n; i++) begin
      @(posedge wr_clk); #1;
      if (cons_busy || exp_pend) exp_ovr = 1;
      else begin
        exp_bank = ~exp_bank; exp_pend = 1;
        if (clr) exp_ovr = 0;
      end
      @(negedge wr_clk);
    end
    wr_done = 0; ovr_clr = 0;
  endtask

  task automatic clear_ovr();
    @(negedge wr_clk);
    ovr_clr = 1;
    @(posedge wr_clk); #1;
    exp_ovr = 0;
    @(negedge wr_clk);
    ovr_clr = 0;
  endtask

  task automatic wait_swap(input logic exp_rd_bank);
    int t = 0;
    @(negedge rd_clk);
    while (!irq && t < 100) begin @(negedge rd_clk); t++; end
    check(irq == 1, "R4 irq raised", irq, 1);
    check(data_rdy == 1, "R4 rdy with irq", data_rdy, 1);
    check(rd_bank == exp_rd_bank, "R4 rd_bank flip", rd_bank, exp_rd_bank);
    @(negedge rd_clk);
    check(irq == 0, "R4 irq one cycle", irq, 0);
    repeat (6) @(negedge wr_clk);
    exp_pend = 0;
    check(rd_bank == ~wr_bank, "R8 banks complementary", rd_bank, ~wr_bank);
  endtask

  task automatic rd_check(input int bank, input int a, input string req);
    @(negedge rd_clk);
    rd_addr = a[BANK_AW-1:0];
    @(negedge rd_clk);
    check(rd_data == sb[bank][a], req, rd_data, sb[bank][a]);
  endtask

  task automatic wait_busy_sync();
    repeat (8) @(negedge wr_clk);
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    addrs = '{0, 1, 2, 5, 9, 15, DEPTH-1};
    repeat (4) @(negedge wr_clk);
    rst_n = 1;
    @(negedge rd_clk);
    check(wr_bank == 0, "R1 wr_bank", wr_bank, 0);
    check(rd_bank == 1, "R1 rd_bank", rd_bank, 1);
    check(data_rdy == 0, "R1 rdy", data_rdy, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(overrun == 0, "R1 overrun", overrun, 0);
    @(negedge wr_clk);
    cmp_on = 1;

    // first symbol into bank 0
    foreach (addrs[i]) wr_word(addrs[i], 32'hA000_0000 + addrs[i] * 32'h11);
    done_cycles(1, 0);
    wait_swap(0);
    foreach (addrs[i]) rd_check(0, addrs[i], "R2 readback bank0");

    // consumer takes the bank
    @(negedge rd_clk); cons_busy = 1;
    @(negedge rd_clk);
    check(data_rdy == 0, "R5 rdy falls on busy", data_rdy, 0);
    wait_busy_sync();

    // symbol into bank 1 dropped while busy
    foreach (addrs[i]) wr_word(addrs[i], 32'hB000_0000 ^ (addrs[i] * 32'h3579));
    done_cycles(1, 0);
    check(wr_bank == 1, "R6 bank held on drop", wr_bank, 1);
    check(rd_bank == 0, "R6 rd bank held", rd_bank, 0);
    foreach (addrs[i]) rd_check(0, addrs[i], "R6 read bank untouched");
    done_cycles(1, 1);
    check(overrun == 1, "R7 drop beats clear", overrun, 1);
    clear_ovr();
    check(overrun == 0, "R7 clear", overrun, 0);

    // consumer releases, swap now allowed
    @(negedge rd_clk); cons_busy = 0;
    wait_busy_sync();
    done_cycles(1, 0);
    wait_swap(1);
    foreach (addrs[i]) rd_check(1, addrs[i], "R2 readback bank1");

    // back-to-back done: second sees pending handshake
    wr_word(3, 32'hC0DE_0003);
    done_cycles(2, 0);
    check(overrun == 1, "R6 pending drop", overrun, 1);
    wait_swap(0);
    repeat (10) @(negedge rd_clk);
    check(rd_bank == 0, "R4 single flip", rd_bank, 0);
    rd_check(0, 3, "R2 readback after pending drop");
    clear_ovr();

    repeat (4) @(negedge wr_clk);
    finish_run();
  end
endmodule